// File: doc/BRIEF.md
# PCI 64-bit Transfer Width Negotiator

This block sits inside the DMA engine of a PCI bus master. For each DMA request (a bus command code, a start address and a byte count) it decides whether a 64-bit transaction is worth attempting. It drives FRAME_ and REQ64_ for the address phase and watches DEVSEL_ and ACK64_ from the target. It then tells the data-phase logic whether each data phase moves 64 or 32 bits. It also keeps the bus address and the remaining byte count up to date as phases complete.

Whether the system has a 64-bit path at all is learned once, while reset is held, from the level on a REQ64_ sense input. If the target ends a burst right after its first data phase, the rest of the request is reissued as a fresh transaction that may only use 32-bit phases. That restriction is lifted when the next request is taken. Arbitration, parity and wait-state detail are outside the block: the target side is reduced to DEVSEL_, ACK64_, TRDY_ and STOP_ levels sampled on the rising clock edge.

Top module: `pci_width_negotiator`

## Requirements
- R1: `req64_sense_n` is sampled on every clock edge while `rst_n` is low. A low level marks the system as 64-bit capable. A high level, which is the pulled-up default, means `req64_n` is never driven low until the next reset.
- R2: A 64-bit attempt is made only for memory commands, that is command codes 4'h6, 4'h7, 4'hC, 4'hE and 4'hF. Every other code keeps `req64_n` high.
- R3: A 64-bit attempt needs a remaining byte count of at least 16.
- R4: When `align_en` is 1, a 64-bit attempt also needs the low three address bits to be zero. When `align_en` is 0, the start address does not matter.
- R5: In the cycle after a request is accepted (`req_valid` high while `req_ready` is high), `frame_n` goes low. `req64_n` goes low in that same cycle if an attempt is made, and `bus_addr` shows the start address.
- R6: Once DEVSEL_ is seen low, data phases are 64 bits wide (`wide_mode` = 1) only if an attempt was made and ACK64_ was low in the same cycle as DEVSEL_. Otherwise `wide_mode` = 0.
- R7: DEVSEL_ is sampled on the five rising edges that follow the start of FRAME_. If it is high on all five, then in the next cycle `master_abort` pulses for one cycle, FRAME_ and REQ64_ are high and the block is idle again.
- R8: `frame_n`, and `req64_n` when it was asserted, go high during the final data phase, which is the phase in which the remaining count is no more than the phase size.
- R9: Each data phase completed with TRDY_ low adds 8 (64-bit) or 4 (32-bit) to `bus_addr` and subtracts the same amount from the count, saturating at zero. In the cycle after the count reaches zero, `xfer_done` pulses for one cycle and the block is idle.
- R10: If STOP_ and TRDY_ are both low on the first data phase of a transaction and data remains, the next cycle is a bus-idle cycle with FRAME_ high. The remainder is then reissued at the current address, and `req64_n` stays high for it.
- R11: The forced 32-bit restriction is cleared when the next request is accepted. A disconnect after a later data phase reissues the remainder under the normal rules of R1 to R4.
- R12: After reset, `frame_n` and `req64_n` are high, `req_ready` is high, and `xfer_done` and `master_abort` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst_n | input | 1 | Active-low reset (RST_) |
| req64_sense_n | input | 1 | REQ64_ level as seen during reset |
| align_en | input | 1 | Require 8-byte alignment for a 64-bit attempt |
| req_valid | input | 1 | DMA request present |
| req_cmd | input | 4 | PCI bus command code |
| req_addr | input | 32 | Start byte address |
| req_bytes | input | 16 | Byte count |
| req_ready | output | 1 | Idle; request accepted when valid |
| frame_n | output | 1 | FRAME_ |
| req64_n | output | 1 | REQ64_ |
| devsel_n | input | 1 | DEVSEL_ from target |
| ack64_n | input | 1 | ACK64_ from target |
| trdy_n | input | 1 | TRDY_, data phase completes |
| stop_n | input | 1 | STOP_, target disconnect |
| bus_addr | output | 32 | Address of current phase |
| wide_mode | output | 1 | 1 = 64-bit data phases |
| xfer_done | output | 1 | One-cycle pulse, request complete |
| master_abort | output | 1 | One-cycle pulse, no target claimed |

## Verification
FRAME_, REQ64_ and the address appear in the cycle right after the accepting edge. The width flag appears in the cycle after the edge that sampled DEVSEL_ low. The master-abort pulse comes five edges after FRAME_ starts. The done pulse and the bus-idle cycle of a restart follow directly on the edge of the last or disconnected data phase. The bench drives every input on the falling edge and reads the outputs at the next falling edge, after the rising edge that updates them. It works out each expected level from its own model of the command, count, alignment, capability and forced-narrow rules.

// File: rtl/pwn_pkg.sv
package pwn_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CLAIM = 2'd1,
        ST_DATA  = 2'd2,
        ST_TURN  = 2'd3
    } ctrl_state_e;

    // Memory-space command codes that may use a 64-bit data path
    function automatic logic is_mem_cmd(input logic [3:0] code);
        return (code == 4'h6) || (code == 4'h7) || (code == 4'hC) ||
               (code == 4'hE) || (code == 4'hF);
    endfunction

endpackage

// File: rtl/pwn_cap_latch.sv
module pwn_cap_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic sense_n,
    output logic cap64
);
    logic cap_q;

    // Loaded only while reset is held; retained afterwards
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= ~sense_n;
        end
    end

    assign cap64 = cap_q;

endmodule

// File: rtl/pwn_width_decide.sv
module pwn_width_decide #(
    parameter int CW        = 16,
    parameter int MIN_BYTES = 16
) (
    input  logic          cap64,
    input  logic          align_en,
    input  logic          force32,
    input  logic [3:0]    cmd,
    input  logic [2:0]    addr_lo,
    input  logic [CW-1:0] bytes,
    output logic          try64
);
    import pwn_pkg::*;

    logic long_enough;
    logic aligned_ok;

    always_comb begin
        long_enough = (bytes >= CW'(MIN_BYTES));
        aligned_ok  = !align_en || (addr_lo == 3'b000);
        try64       = cap64 && is_mem_cmd(cmd) && long_enough && aligned_ok && !force32;
    end

endmodule

// File: rtl/pwn_ctrl.sv
module pwn_ctrl #(
    parameter int AW          = 32,
    parameter int CW          = 16,
    parameter int CLAIM_LIMIT = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [3:0]    req_cmd,
    input  logic [AW-1:0] req_addr,
    input  logic [CW-1:0] req_bytes,
    input  logic          devsel_n,
    input  logic          ack64_n,
    input  logic          trdy_n,
    input  logic          stop_n,
    input  logic          try64,
    output logic [3:0]    dec_cmd,
    output logic [2:0]    dec_addr_lo,
    output logic [CW-1:0] dec_bytes,
    output logic          dec_force,
    output logic          req_ready,
    output logic          frame_n,
    output logic          req64_n,
    output logic [AW-1:0] bus_addr,
    output logic          wide_mode,
    output logic          xfer_done,
    output logic          master_abort,
    output logic [3:0]    cmd_hold,
    output logic          force32
);
    import pwn_pkg::*;

    localparam int TW = $clog2(CLAIM_LIMIT + 1);
    localparam int NARROW_BYTES = 4;
    localparam int WIDE_BYTES   = 8;

    typedef struct packed {
        ctrl_state_e   st;
        logic [3:0]    cmd;
        logic [AW-1:0] addr;
        logic [CW-1:0] cnt;
        logic          force32;
        logic          try64;
        logic          wide;
        logic          first;
        logic [TW-1:0] timer;
        logic          frame_n;
        logic          req64_n;
        logic          done;
        logic          mabort;
    } regs_t;

    localparam regs_t RESET_VAL = '{
        st: ST_IDLE, cmd: '0, addr: '0, cnt: '0, force32: 1'b0, try64: 1'b0,
        wide: 1'b0, first: 1'b0, timer: '0, frame_n: 1'b1, req64_n: 1'b1,
        done: 1'b0, mabort: 1'b0
    };

    regs_t q, d;
    logic [CW-1:0] step;
    logic [CW-1:0] claim_step;
    logic [CW-1:0] rem_after;

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        d.mabort = 1'b0;

        step      = q.wide ? CW'(WIDE_BYTES) : CW'(NARROW_BYTES);
        rem_after = (q.cnt > step) ? (q.cnt - step) : '0;
        claim_step = CW'(NARROW_BYTES);

        // Width decision inputs: fresh request when idle, held state otherwise
        if (q.st == ST_IDLE) begin
            dec_cmd     = req_cmd;
            dec_addr_lo = req_addr[2:0];
            dec_bytes   = req_bytes;
            dec_force   = 1'b0;
        end else begin
            dec_cmd     = q.cmd;
            dec_addr_lo = q.addr[2:0];
            dec_bytes   = q.cnt;
            dec_force   = q.force32;
        end

        case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.cmd     = req_cmd;
                    d.addr    = req_addr;
                    d.cnt     = req_bytes;
                    d.force32 = 1'b0;
                    d.try64   = try64;
                    d.wide    = 1'b0;
                    d.timer   = '0;
                    d.frame_n = 1'b0;
                    d.req64_n = ~try64;
                    d.st      = ST_CLAIM;
                end
            end
            ST_CLAIM: begin
                if (!devsel_n) begin
                    d.wide     = q.try64 && !ack64_n;
                    claim_step = d.wide ? CW'(WIDE_BYTES) : CW'(NARROW_BYTES);
                    d.frame_n  = (q.cnt <= claim_step);
                    d.req64_n  = d.frame_n || !q.try64;
                    d.first    = 1'b1;
                    d.st       = ST_DATA;
                end else if (q.timer == TW'(CLAIM_LIMIT - 1)) begin
                    d.mabort  = 1'b1;
                    d.frame_n = 1'b1;
                    d.req64_n = 1'b1;
                    d.wide    = 1'b0;
                    d.st      = ST_IDLE;
                end else begin
                    d.timer = q.timer + TW'(1);
                end
            end
            ST_DATA: begin
                if (!trdy_n) begin
                    d.cnt   = rem_after;
                    d.addr  = q.addr + AW'(step);
                    d.first = 1'b0;
                    if (rem_after == '0) begin
                        d.done    = 1'b1;
                        d.frame_n = 1'b1;
                        d.req64_n = 1'b1;
                        d.wide    = 1'b0;
                        d.st      = ST_IDLE;
                    end else if (!stop_n) begin
                        d.force32 = q.force32 || q.first;
                        d.frame_n = 1'b1;
                        d.req64_n = 1'b1;
                        d.wide    = 1'b0;
                        d.st      = ST_TURN;
                    end else begin
                        d.frame_n = (rem_after <= step);
                        d.req64_n = d.frame_n || !q.try64;
                    end
                end else if (!stop_n) begin
                    d.frame_n = 1'b1;
                    d.req64_n = 1'b1;
                    d.wide    = 1'b0;
                    d.st      = ST_TURN;
                end
            end
            default: begin
                // Bus-idle cycle, then reissue the remainder
                d.try64   = try64;
                d.timer   = '0;
                d.frame_n = 1'b0;
                d.req64_n = ~try64;
                d.st      = ST_CLAIM;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= RESET_VAL;
        end else begin
            q <= d;
        end
    end

    assign req_ready    = (q.st == ST_IDLE);
    assign frame_n      = q.frame_n;
    assign req64_n      = q.req64_n;
    assign bus_addr     = q.addr;
    assign wide_mode    = q.wide;
    assign xfer_done    = q.done;
    assign master_abort = q.mabort;
    assign cmd_hold     = q.cmd;
    assign force32      = q.force32;

endmodule

// File: rtl/pci_width_negotiator.sv
module pci_width_negotiator #(
    parameter int AW          = 32,
    parameter int CW          = 16,
    parameter int CLAIM_LIMIT = 5,
    parameter int MIN_BYTES   = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req64_sense_n,
    input  logic          align_en,
    input  logic          req_valid,
    input  logic [3:0]    req_cmd,
    input  logic [AW-1:0] req_addr,
    input  logic [CW-1:0] req_bytes,
    output logic          req_ready,
    output logic          frame_n,
    output logic          req64_n,
    input  logic          devsel_n,
    input  logic          ack64_n,
    input  logic          trdy_n,
    input  logic          stop_n,
    output logic [AW-1:0] bus_addr,
    output logic          wide_mode,
    output logic          xfer_done,
    output logic          master_abort
);
    logic          cap64;
    logic          try64;
    logic [3:0]    dec_cmd;
    logic [2:0]    dec_addr_lo;
    logic [CW-1:0] dec_bytes;
    logic          dec_force;
    logic [3:0]    cmd_hold;
    logic          force32;

    pwn_cap_latch u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .sense_n (req64_sense_n),
        .cap64   (cap64)
    );

    pwn_width_decide #(.CW(CW), .MIN_BYTES(MIN_BYTES)) u_dec (
        .cap64    (cap64),
        .align_en (align_en),
        .force32  (dec_force),
        .cmd      (dec_cmd),
        .addr_lo  (dec_addr_lo),
        .bytes    (dec_bytes),
        .try64    (try64)
    );

    pwn_ctrl #(.AW(AW), .CW(CW), .CLAIM_LIMIT(CLAIM_LIMIT)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_cmd      (req_cmd),
        .req_addr     (req_addr),
        .req_bytes    (req_bytes),
        .devsel_n     (devsel_n),
        .ack64_n      (ack64_n),
        .trdy_n       (trdy_n),
        .stop_n       (stop_n),
        .try64        (try64),
        .dec_cmd      (dec_cmd),
        .dec_addr_lo  (dec_addr_lo),
        .dec_bytes    (dec_bytes),
        .dec_force    (dec_force),
        .req_ready    (req_ready),
        .frame_n      (frame_n),
        .req64_n      (req64_n),
        .bus_addr     (bus_addr),
        .wide_mode    (wide_mode),
        .xfer_done    (xfer_done),
        .master_abort (master_abort),
        .cmd_hold     (cmd_hold),
        .force32      (force32)
    );

endmodule

// File: rtl/pwn_checker.sv
module pwn_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cap64,
    input logic       frame_n,
    input logic       req64_n,
    input logic [3:0] cmd_hold,
    input logic       force32,
    input logic       req_ready,
    input logic       xfer_done,
    input logic       master_abort
);
    import pwn_pkg::*;

    assert_no_req64_without_cap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !cap64 |-> req64_n);

    assert_req64_memory_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req64_n |-> is_mem_cmd(cmd_hold));

    assert_req64_inside_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !req64_n |-> !frame_n);

    assert_abort_frees_bus_R7: assert property (@(posedge clk) disable iff (!rst_n)
        master_abort |-> (frame_n && req64_n && req_ready));

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> !xfer_done);

    assert_idle_bus_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (frame_n && req64_n));

    assert_forced_narrow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        force32 |-> req64_n);

endmodule

bind pci_width_negotiator pwn_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cap64        (cap64),
    .frame_n      (frame_n),
    .req64_n      (req64_n),
    .cmd_hold     (cmd_hold),
    .force32      (force32),
    .req_ready    (req_ready),
    .xfer_done    (xfer_done),
    .master_abort (master_abort)
);

// File: tb/pci_width_negotiator_test.sv
`timescale 1ns/1ps
module pci_width_negotiator_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req64_sense_n = 1'b1;
    logic        align_en = 1'b0;
    logic        req_valid = 1'b0;
    logic [3:0]  req_cmd = 4'h0;
    logic [31:0] req_addr = 32'h0;
    logic [15:0] req_bytes = 16'h0;
    logic        req_ready;
    logic        frame_n;
    logic        req64_n;
    logic        devsel_n = 1'b1;
    logic        ack64_n = 1'b1;
    logic        trdy_n = 1'b1;
    logic        stop_n = 1'b1;
    logic [31:0] bus_addr;
    logic        wide_mode;
    logic        xfer_done;
    logic        master_abort;

    int  checks = 0;
    int  failures = 0;
    bit  cap_exp = 1'b0;
    bit  after_force = 1'b0;
    bit  reported = 1'b0;

    always #10 clk = ~clk;

    pci_width_negotiator uut (
        .clk(clk), .rst_n(rst_n), .req64_sense_n(req64_sense_n), .align_en(align_en),
        .req_valid(req_valid), .req_cmd(req_cmd), .req_addr(req_addr), .req_bytes(req_bytes),
        .req_ready(req_ready), .frame_n(frame_n), .req64_n(req64_n), .devsel_n(devsel_n),
        .ack64_n(ack64_n), .trdy_n(trdy_n), .stop_n(stop_n), .bus_addr(bus_addr),
        .wide_mode(wide_mode), .xfer_done(xfer_done), .master_abort(master_abort)
    );

    function automatic bit mem_code(input logic [3:0] c);
        return (c == 4'h6) || (c == 4'h7) || (c == 4'hC) || (c == 4'hE) || (c == 4'hF);
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic do_reset(input logic sense_n);
        rst_n = 1'b0;
        req64_sense_n = sense_n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cap_exp = !sense_n;
        @(negedge clk);
        chk(frame_n == 1'b1, "R12 frame_n", longint'(frame_n), 1);
        chk(req64_n == 1'b1, "R12 req64_n", longint'(req64_n), 1);
        chk(req_ready == 1'b1, "R12 req_ready", longint'(req_ready), 1);
        chk(xfer_done == 1'b0 && master_abort == 1'b0, "R12 pulses",
            longint'({xfer_done, master_abort}), 0);
    endtask

    // Called at a falling edge with the block idle
    task automatic run_case(input logic [3:0] cmd, input logic [31:0] addr, input int bytes,
                            input bit align, input int dly, input bit ack, input int disc);
        int rem; logic [31:0] a; bit forced; bit tr; bit wd; bit first_txn;
        bit stopped; bit endit; int step; int ptx; int phase; int d; string tag;
        align_en  = align;
        req_valid = 1'b1;
        req_cmd   = cmd;
        req_addr  = addr;
        req_bytes = 16'(bytes);
        @(negedge clk);
        req_valid = 1'b0;
        rem = bytes; a = addr; forced = 1'b0; first_txn = 1'b1; phase = 0; endit = 1'b0;
        while (!endit) begin
            tr = cap_exp && mem_code(cmd) && (rem >= 16) && (!align || a[2:0] == 3'b000) && !forced;
            if (!cap_exp) tag = "R1 req64_n";
            else if (!mem_code(cmd)) tag = "R2 req64_n";
            else if (rem < 16) tag = "R3 req64_n";
            else if (forced) tag = "R10 req64_n";
            else if (!first_txn || after_force) tag = "R11 req64_n";
            else tag = "R4 req64_n";
            chk(frame_n == 1'b0, "R5 frame_n", longint'(frame_n), 0);
            chk(req64_n == !tr, tag, longint'(req64_n), longint'(!tr));
            chk(bus_addr == a, "R5 bus_addr", longint'(bus_addr), longint'(a));
            d = first_txn ? dly : 0;
            if (d >= 5) begin
                repeat (5) @(negedge clk);
                chk(master_abort == 1'b1, "R7 master_abort", longint'(master_abort), 1);
                chk(frame_n && req64_n && req_ready, "R7 bus released",
                    longint'({frame_n, req64_n, req_ready}), 7);
                @(negedge clk);
                chk(master_abort == 1'b0, "R7 pulse width", longint'(master_abort), 0);
                return;
            end
            repeat (d) @(negedge clk);
            if (d > 0) chk(frame_n == 1'b0 && wide_mode == 1'b0, "R7 still waiting",
                           longint'(frame_n), 0);
            devsel_n = 1'b0;
            ack64_n  = !ack;
            @(negedge clk);
            wd = tr && ack;
            step = wd ? 8 : 4;
            ptx = 0;
            stopped = 1'b0;
            while (!stopped && !endit) begin
                chk(wide_mode == wd, "R6 wide_mode", longint'(wide_mode), longint'(wd));
                chk(bus_addr == a, "R9 bus_addr", longint'(bus_addr), longint'(a));
                chk(frame_n == (rem <= step), "R8 frame_n", longint'(frame_n),
                    longint'(rem <= step));
                chk(req64_n == ((rem <= step) || !tr), "R8 req64_n", longint'(req64_n),
                    longint'((rem <= step) || !tr));
                trdy_n = 1'b0;
                stop_n = (phase == disc) ? 1'b0 : 1'b1;
                @(negedge clk);
                stopped = (phase == disc);
                trdy_n = 1'b1;
                stop_n = 1'b1;
                rem = (rem > step) ? rem - step : 0;
                a = a + 32'(step);
                phase++;
                ptx++;
                if (rem == 0) begin
                    devsel_n = 1'b1; ack64_n = 1'b1;
                    chk(xfer_done == 1'b1, "R9 xfer_done", longint'(xfer_done), 1);
                    chk(req_ready && frame_n, "R9 idle after done",
                        longint'({req_ready, frame_n}), 3);
                    endit = 1'b1;
                end else if (stopped) begin
                    devsel_n = 1'b1; ack64_n = 1'b1;
                    chk(frame_n == 1'b1 && xfer_done == 1'b0, "R10 idle cycle",
                        longint'({frame_n, xfer_done}), 2);
                    if (ptx == 1) forced = 1'b1;
                    @(negedge clk);
                    first_txn = 1'b0;
                end
            end
        end
    endtask

    initial begin
        #(20 * 150000);
        failures++;
        $display("FAIL watchdog expired actual=0 expected=1");
        if (!reported) begin
            reported = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        end
        $finish;
    end

    initial begin
        // R1: system without a 64-bit path
        do_reset(1'b1);
        for (int c = 0; c < 16; c++) begin
            run_case(4'(c), 32'h0000_0100, 32, 1'b0, 0, 1'b1, -1);
        end

        // R1: 64-bit capable system, sweep of command, alignment, offset, count, acknowledge
        do_reset(1'b0);
        for (int c = 0; c < 16; c++) begin
            for (int al = 0; al < 2; al++) begin
                for (int off = 0; off < 2; off++) begin
                    for (int bi = 0; bi < 5; bi++) begin
                        for (int ak = 0; ak < 2; ak++) begin
                            int nb;
                            case (bi)
                                0: nb = 8;
                                1: nb = 12;
                                2: nb = 16;
                                3: nb = 20;
                                default: nb = 40;
                            endcase
                            run_case(4'(c), 32'h0000_1000 + 32'(off * 4), nb, al[0], 0, ak[0], -1);
                        end
                    end
                end
            end
        end

        // R7: claim delay up to and beyond the window
        for (int dl = 0; dl < 7; dl++) begin
            run_case(4'h7, 32'h0000_2000, 24, 1'b1, dl, 1'b1, -1);
        end

        // R10 and R11: disconnects at several phases, then a fresh request
        for (int ds = 0; ds < 4; ds++) begin
            for (int ak = 0; ak < 2; ak++) begin
                run_case(4'h6, 32'h0000_3000, 48, 1'b1, 0, ak[0], ds);
                after_force = 1'b1;
                run_case(4'h6, 32'h0000_4000, 32, 1'b1, 0, 1'b1, -1);
                after_force = 1'b0;
            end
        end

        // R12: reset again mid-life restores idle outputs
        do_reset(1'b0);

        if (!reported) begin
            reported = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        end
        $finish;
    end

endmodule